// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block merges the interrupt requests of a small computer's main I/O area into one CPU IRQ line, and drives a second fast-interrupt line from a break key and a sub-processor attention signal. Three sources are latched as pending flags: an internal periodic timer, a printer and a keyboard. Each flag is gated by its own enable bit. The floppy controller and a parameterised number of sound chips are level sources. The floppy source is gated by its enable bit. The sound sources are not gated. A one-bit summary of these level sources appears in the status byte.

Software writes the enable register and reads an active-low status byte through a byte-wide port with a small address. Reads have side effects. Reading the status byte clears the timer and printer flags. Reading the keyboard data port clears the keyboard flag. Reading the fast-interrupt status port clears the attention flag. Read data is registered and appears on the cycle after the read strobe.

Top module: `isc_ctrl`

## Requirements
- R1: While and after reset, irq and firq are 0, all enables are 0, and a status read at address 0 returns 0xFF.
- R2: A write to address 0 loads the enables: wdata bit 4 enables the floppy source, bit 2 the timer, bit 1 the printer and bit 0 the keyboard. A 1 enables. Bits 7..5 and 3 are ignored.
- R3: A request held high on a clock edge while its enable bit is 1 makes that source pending. A pending source reads low in the status byte: bit 2 for the timer, bit 1 for the printer, bit 0 for the keyboard. A request made while the source is disabled leaves the status at 0xFF and irq at 0.
- R4: Status bits 7..4 always read 1. Bit 3 reads 0 when, on the previous edge, the floppy request was high with its enable set, or any sound request was high.
- R5: A status read clears the timer and printer flags but not the keyboard flag. If a request arrives on the same edge as the read, the flag stays set.
- R6: A read at address 1 returns key_data and clears the keyboard flag.
- R7: irq is 1 exactly when a latched flag is set or the registered level-source summary is active.
- R8: The timer requests once every TICK_CYCLES clock cycles.
- R9: Clearing an enable bit clears that source's flag on the same edge. This takes priority over a request arriving on that edge.
- R10: firq is 1 on the cycle after break_key is high. It is also 1 while the attention flag is set. The flag is set by a rising edge of sub_attn.
- R11: A read at address 2 returns bits 7..2 as 1, bit 1 as 0 while break is active, and bit 0 as 0 while the attention flag is set. The read clears the attention flag unless a new rising edge of sub_attn arrives on the same edge.
- R12: Reads return data on the cycle after rd_en. A read at address 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| key_data | input | 8 | Keyboard code returned at address 1 |
| key_req | input | 1 | Keyboard interrupt request |
| prn_req | input | 1 | Printer interrupt request |
| fdc_req | input | 1 | Floppy controller interrupt level |
| snd_req | input | NUM_SND | Sound chip interrupt levels |
| break_key | input | 1 | Break key level |
| sub_attn | input | 1 | Sub-processor attention level |
| irq | output | 1 | CPU interrupt request |
| firq | output | 1 | CPU fast interrupt request |

## Verification
Every result is due one clock edge after its stimulus. A request sampled on an edge sets a flag or the registered level summary, and irq follows combinationally from those registers. A read strobe yields rdata and clears the flag on the same edge. The bench drives all inputs on the falling edge and samples at the next falling edge, so each check reads the value due after exactly one rising edge. The timer check counts the cycles between two irq rises, with a clearing read between them, and compares the count with the period parameter.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int REG_AW = 2;
   localparam logic [REG_AW-1:0] A_STAT  = 2'd0;
   localparam logic [REG_AW-1:0] A_KEY   = 2'd1;
   localparam logic [REG_AW-1:0] A_FIRQ  = 2'd2;
   localparam int NUM_LATCH = 3;
   localparam int B_KEY = 0;
   localparam int B_PRN = 1;
   localparam int B_TMR = 2;
   localparam int B_EXT = 3;
   localparam int B_FDC = 4;
endpackage

// File: rtl/isc_tick.sv
module isc_tick #(
   parameter int TICK_CYCLES = 101750
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

   initial begin
      assert (TICK_CYCLES >= 2) else $error("TICK_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/isc_flag.sv
module isc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic en,
   input  logic clr_rd,
   input  logic kill,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)         pend <= 1'b0;
      else if (kill)      pend <= 1'b0;
      else if (req && en) pend <= 1'b1;
      else if (clr_rd)    pend <= 1'b0;
   end
endmodule

// File: rtl/isc_firq.sv
module isc_firq (
   input  logic clk,
   input  logic rst_n,
   input  logic break_key,
   input  logic sub_attn,
   input  logic clr_attn,
   output logic brk_q,
   output logic attn_q,
   output logic firq
);
   logic attn_prev;
   logic attn_rise;

   assign attn_rise = sub_attn && !attn_prev;
   assign firq      = brk_q || attn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk_q     <= 1'b0;
         attn_q    <= 1'b0;
         attn_prev <= 1'b0;
      end else begin
         brk_q     <= break_key;
         attn_prev <= sub_attn;
         if (attn_rise)     attn_q <= 1'b1;
         else if (clr_attn) attn_q <= 1'b0;
      end
   end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
   import isc_pkg::*;
#(
   parameter int NUM_SND     = 3,
   parameter int TICK_CYCLES = 101750,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [7:0]        key_data,
   input  logic              key_req,
   input  logic              prn_req,
   input  logic              fdc_req,
   input  logic [NUM_SND-1:0] snd_req,
   input  logic              break_key,
   input  logic              sub_attn,
   output logic              irq,
   output logic              firq
);
   initial begin
      assert (NUM_SND >= 1) else $error("NUM_SND must be at least 1");
      assert (ADDR_W >= REG_AW) else $error("ADDR_W too narrow");
   end

   logic                 wr_mask, rd_stat, rd_key, rd_firq;
   logic [NUM_LATCH-1:0] en_q, req_v, clr_v, kill_v, pend_v;
   logic                 en_fdc_q, en_fdc_nxt;
   logic                 ext_q;
   logic                 tick;
   logic                 brk_q, attn_q;
   logic [7:0]           rd_mux;

   assign wr_mask = wr_en && (addr == ADDR_W'(A_STAT));
   assign rd_stat = rd_en && (addr == ADDR_W'(A_STAT));
   assign rd_key  = rd_en && (addr == ADDR_W'(A_KEY));
   assign rd_firq = rd_en && (addr == ADDR_W'(A_FIRQ));

   isc_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   assign req_v[B_KEY] = key_req;
   assign req_v[B_PRN] = prn_req;
   assign req_v[B_TMR] = tick;
   assign clr_v[B_KEY] = rd_key;
   assign clr_v[B_PRN] = rd_stat;
   assign clr_v[B_TMR] = rd_stat;

   for (genvar g = 0; g < NUM_LATCH; g++) begin : g_src
      assign kill_v[g] = wr_mask && !wdata[g];
      isc_flag u_flag (
         .clk(clk), .rst_n(rst_n), .req(req_v[g]), .en(en_q[g]),
         .clr_rd(clr_v[g]), .kill(kill_v[g]), .pend(pend_v[g])
      );
   end

   assign en_fdc_nxt = wr_mask ? wdata[B_FDC] : en_fdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         en_fdc_q <= 1'b0;
         ext_q    <= 1'b0;
      end else begin
         if (wr_mask) en_q <= wdata[NUM_LATCH-1:0];
         en_fdc_q <= en_fdc_nxt;
         ext_q    <= (fdc_req && en_fdc_nxt) || (|snd_req);
      end
   end

   isc_firq u_firq (
      .clk(clk), .rst_n(rst_n), .break_key(break_key), .sub_attn(sub_attn),
      .clr_attn(rd_firq), .brk_q(brk_q), .attn_q(attn_q), .firq(firq)
   );

   assign irq = (|pend_v) || ext_q;

   always_comb begin
      rd_mux = 8'hFF;
      if (addr == ADDR_W'(A_STAT)) begin
         rd_mux[B_EXT]         = !ext_q;
         rd_mux[NUM_LATCH-1:0] = ~pend_v;
      end else if (addr == ADDR_W'(A_KEY)) begin
         rd_mux = key_data;
      end else if (addr == ADDR_W'(A_FIRQ)) begin
         rd_mux[1] = !brk_q;
         rd_mux[0] = !attn_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= 8'hFF;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/isc_ctrl_chk.sv
module isc_ctrl_chk #(
   parameter int NUM_SND = 3,
   parameter int ADDR_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [7:0]         wdata,
   input logic [7:0]         rdata,
   input logic [NUM_SND-1:0] snd_req,
   input logic               break_key,
   input logic               irq,
   input logic               firq
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!irq && !firq));
   // R10
   brk_firq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      break_key |=> firq);
   // R4
   stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(0)) |=> (rdata[7:4] == 4'hF));
   // R11
   firq_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(2)) |=> (rdata[7:2] == 6'h3F));
   // R9
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(0) && wdata[4:0] == 5'd0 && snd_req == '0) |=> !irq);
   // R12
   spare_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(3)) |=> (rdata == 8'hFF));
endmodule

bind isc_ctrl isc_ctrl_chk #(.NUM_SND(NUM_SND), .ADDR_W(ADDR_W)) u_isc_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .snd_req(snd_req), .break_key(break_key),
   .irq(irq), .firq(firq)
);

// File: tb/test_isc_ctrl.sv
module test_isc_ctrl;
   localparam int NS = 3;
   localparam int TP = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0, key_data = 8'h5A;
   logic [7:0] rdata;
   logic key_req = 0, prn_req = 0, fdc_req = 0, break_key = 0, sub_attn = 0;
   logic [NS-1:0] snd_req = '0;
   logic irq, firq;
   int checks = 0, errors = 0, cyc = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   isc_ctrl #(.NUM_SND(NS), .TICK_CYCLES(TP), .ADDR_W(2)) i_isc_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .key_data(key_data), .key_req(key_req),
      .prn_req(prn_req), .fdc_req(fdc_req), .snd_req(snd_req),
      .break_key(break_key), .sub_attn(sub_attn), .irq(irq), .firq(firq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0; d = rdata;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 irq", irq, 0); chk("R1 firq", firq, 0);
      rd(0, d); chk("R1 status", d, 8'hFF);
      prn_req = 1; key_req = 1; @(negedge clk); prn_req = 0; key_req = 0;
      rd(0, d); chk("R3 disabled ignored", d, 8'hFF); chk("R3 irq off", irq, 0);
   endtask

   task automatic t_pending;
      logic [7:0] d;
      wr(0, 8'hEB);
      prn_req = 1; @(negedge clk); prn_req = 0;
      chk("R7 irq printer", irq, 1);
      key_req = 1; @(negedge clk); key_req = 0;
      rd(0, d); chk("R3 printer+key", d, 8'hFC);
      rd(0, d); chk("R5 key kept", d, 8'hFE);
      rd(1, d); chk("R6 key data", d, 8'h5A);
      rd(0, d); chk("R6 key cleared", d, 8'hFF); chk("R7 irq off", irq, 0);
      prn_req = 1; rd(0, d); prn_req = 0;
      chk("R5 read before set", d, 8'hFF);
      rd(0, d); chk("R5 set wins", d, 8'hFD);
      rd(0, d); chk("R5 cleared", d, 8'hFF);
      wr(0, 8'h00);
   endtask

   task automatic t_ext;
      logic [7:0] d;
      fdc_req = 1; @(negedge clk);
      chk("R2 fdc disabled", irq, 0);
      wr(0, 8'h10);
      chk("R4 fdc irq", irq, 1);
      rd(0, d); chk("R4 fdc summary", d, 8'hF7);
      fdc_req = 0; @(negedge clk); chk("R4 fdc gone", irq, 0);
      snd_req = 3'b100; @(negedge clk);
      rd(0, d); chk("R4 sound summary", d, 8'hF7);
      snd_req = 0; @(negedge clk);
      rd(0, d); chk("R4 sound gone", d, 8'hFF);
      rd(3, d); chk("R12 spare", d, 8'hFF);
   endtask

   task automatic t_disable;
      logic [7:0] d;
      wr(0, 8'h03);
      key_req = 1; @(negedge clk);
      chk("R7 key irq", irq, 1);
      wr(0, 8'h02); key_req = 0;
      chk("R9 disable clears", irq, 0);
      rd(0, d); chk("R9 status", d, 8'hFF);
      wr(0, 8'h00);
   endtask

   task automatic t_timer;
      logic [7:0] d;
      int t0;
      wr(0, 8'h04);
      while (!irq) @(negedge clk);
      t0 = cyc;
      rd(0, d); chk("R3 timer bit", d, 8'hFB);
      while (!irq) @(negedge clk);
      chk("R8 period", cyc - t0, TP);
      wr(0, 8'h00);
   endtask

   task automatic t_firq;
      logic [7:0] d;
      break_key = 1; @(negedge clk);
      chk("R10 break", firq, 1);
      rd(2, d); chk("R11 break bit", d, 8'hFD);
      break_key = 0; @(negedge clk); chk("R10 break off", firq, 0);
      sub_attn = 1; @(negedge clk);
      chk("R10 attn", firq, 1);
      rd(2, d); chk("R11 attn bit", d, 8'hFE);
      chk("R11 attn cleared", firq, 0);
      rd(2, d); chk("R11 level no reset", d, 8'hFF);
      sub_attn = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset; t_pending; t_ext; t_disable; t_timer; t_firq;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule